// File: doc/BRIEF.md
# Per-Context Interrupt Priority Arbiter

This block picks, for every interrupt target context, which pending source should be handed over next. Each source has a programmable priority level. Each context has its own enable mask and its own priority threshold. A source takes part in a context's selection only when it is pending, enabled for that context and has a nonzero priority. The highest priority wins. On a tie, the lower source number wins.

Every context gets three registered results. The first is the winning source number, which a claim read returns. The second is the winner's priority. The third is an interrupt request line towards the processor context. The request line uses the threshold: it is asserted only when the winner's priority is strictly greater than the context threshold. The source number offered for claim does not use the threshold.

Register access, edge/level capture and pending-bit storage sit outside this block. The surrounding logic feeds in the pending vector. A claim clears the pending bit there, and the block shows the next winner one clock later.

Top module: `irq_prio_arb`

## Requirements
- R1: A source whose priority field is 0 never appears as a winner and never causes a request, even when pending and enabled.
- R2: Among eligible sources, the one with the numerically largest priority value is the winner. Priority 1 is the lowest active level and the largest level is 2^PRIO_W-1.
- R3: When several eligible sources share the top priority, the winner is the one with the smallest source number.
- R4: The request line of a context is high only if the winner's priority is strictly greater than that context's threshold. A threshold of 0 passes any winner, and a winner whose priority equals the threshold is masked.
- R5: Source numbers run from 1 to NUM_SRC. Source number 0 is reserved. With no eligible source, a context reports number 0 and priority 0, and its request line is low.
- R6: The winner number and winner priority do not depend on the threshold. A masked winner is still reported for claiming.
- R7: A source is eligible for a context only when its pending bit (pendIn bit s for source s) and that context's enable bit (enIn[c] bit s) are both set. Each context is selected independently of the others.
- R8: All outputs are registered. A change on any input shows on the outputs after the next rising clock edge and not before, so a cleared pending bit yields the next winner one cycle later. While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| pendIn | input | NUM_SRC | Pending bit per source, bit s = source s (range NUM_SRC:1) |
| enIn | input | NUM_CTX x NUM_SRC | Enable mask per context, enIn[c][s] enables source s for context c |
| prioIn | input | NUM_SRC x PRIO_W | Priority level per source, prioIn[s] |
| threshIn | input | NUM_CTX x PRIO_W | Priority threshold per context |
| claimIdOut | output | NUM_CTX x 5 | Winning source number per context, 0 when none |
| claimPrioOut | output | NUM_CTX x PRIO_W | Priority of the winning source per context, 0 when none |
| irqOut | output | NUM_CTX | Interrupt request line per context |

## Verification
A vector table drives mixes of priorities, pending bits and enable masks for two contexts at once. One mix has a clear priority order, which shows that the largest value wins. Another has equal-priority sources at scattered numbers, which shows whether ties go to the low number or the high one. Others have sources that are pending but priority-0, or enabled but not pending, or eligible in only one context, and these show whether the eligibility gating is right. Thresholds below, equal to and above the winner's level show whether the strict comparison holds and whether the claim number stays unaffected. Directed steps then check reset, and check the one-cycle lag when the winner's pending bit drops.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Selection tree is built over a fixed number of leaf slots; slot 0 is
  // the reserved source number and never carries a candidate.
  localparam int SLOT_CNT = 32;
  localparam int ID_W     = $clog2(SLOT_CNT);

  // Per-context strobes handed from control to datapath.
  typedef struct packed {
    logic [SLOT_CNT-1:0] candMask;  // source takes part this cycle
    logic                anyCand;   // at least one candidate present
  } ctxStrobe_t;

endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SRC:1]                   pendIn,
  input  logic [NUM_CTX-1:0][NUM_SRC:1]      enIn,
  input  logic [NUM_SRC:1][PRIO_W-1:0]       prioIn,
  input  logic [NUM_CTX-1:0][PRIO_W-1:0]     threshIn,
  input  logic [NUM_CTX-1:0][PRIO_W-1:0]     winPrio,
  output ctxStrobe_t [NUM_CTX-1:0]           strobes,
  output logic [NUM_CTX-1:0]                 irqOut
);

  logic [NUM_CTX-1:0] irqNext;

  // Eligibility: pending, enabled for this context, and priority above 0.
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      strobes[c] = '0;
      for (int s = 1; s <= NUM_SRC; s++) begin
        strobes[c].candMask[s] = pendIn[s] & enIn[c][s] & (|prioIn[s]);
      end
      strobes[c].anyCand = |strobes[c].candMask;
    end
  end

  // Request line: strictly above threshold.
  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      irqNext[c] = strobes[c].anyCand && (winPrio[c] > threshIn[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= irqNext;
  end

  // A request with no candidate at all would mean a stale or wrong line (R5).
  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
      p_irq_needs_cand_r5: assert property (@(posedge clk) disable iff (!rstN)
        irqOut[c] |-> $past(strobes[c].anyCand));
    end
  endgenerate

endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctxStrobe_t [NUM_CTX-1:0]           strobes,
  input  logic [NUM_SRC:1][PRIO_W-1:0]       prioIn,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]     winPrio,
  output logic [NUM_CTX-1:0][ID_W-1:0]       claimIdOut,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]     claimPrioOut
);

  localparam int LVL_CNT = ID_W;

  logic [NUM_CTX-1:0]             rootVld;
  logic [NUM_CTX-1:0][PRIO_W-1:0] rootPrio;
  logic [NUM_CTX-1:0][ID_W-1:0]   rootId;
  logic [NUM_CTX-1:0][ID_W-1:0]   idNext;

  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      for (genvar lv = 0; lv <= LVL_CNT; lv++) begin : g_lvl
        localparam int NODES = SLOT_CNT >> lv;
        logic [NODES-1:0] vld;
        logic [PRIO_W-1:0] pr [NODES];
        logic [ID_W-1:0]   id [NODES];

        if (lv == 0) begin : g_leaf
          for (genvar n = 0; n < NODES; n++) begin : g_n
            assign vld[n] = strobes[c].candMask[n];
            assign id[n]  = ID_W'(n);
            if (n >= 1 && n <= NUM_SRC) begin : g_src
              assign pr[n] = prioIn[n];
            end else begin : g_none
              assign pr[n] = '0;
            end
          end
        end else begin : g_node
          for (genvar n = 0; n < NODES; n++) begin : g_n
            logic takeLo;
            // Lower-numbered half wins ties: compare (priority, inverted id).
            assign takeLo = g_lvl[lv-1].vld[2*n] &&
                            (!g_lvl[lv-1].vld[2*n+1] ||
                             (g_lvl[lv-1].pr[2*n] >= g_lvl[lv-1].pr[2*n+1]));
            assign vld[n] = g_lvl[lv-1].vld[2*n] | g_lvl[lv-1].vld[2*n+1];
            assign pr[n]  = takeLo ? g_lvl[lv-1].pr[2*n] : g_lvl[lv-1].pr[2*n+1];
            assign id[n]  = takeLo ? g_lvl[lv-1].id[2*n] : g_lvl[lv-1].id[2*n+1];
          end
        end
      end

      assign rootVld[c]  = g_lvl[LVL_CNT].vld[0];
      assign rootPrio[c] = g_lvl[LVL_CNT].pr[0];
      assign rootId[c]   = g_lvl[LVL_CNT].id[0];

      assign winPrio[c] = strobes[c].anyCand ? rootPrio[c] : '0;
      assign idNext[c]  = strobes[c].anyCand ? rootId[c]   : '0;

      // Tree and control must agree on whether anything competes (R5).
      always_comb begin
        if (rstN) p_tree_agrees_r5: assert (rootVld[c] == strobes[c].anyCand);
      end

      // A reported winner always carries a nonzero level (R1).
      p_win_nonzero_prio_r1: assert property (@(posedge clk) disable iff (!rstN)
        (claimIdOut[c] != '0) |-> (claimPrioOut[c] != '0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimIdOut   <= '0;
      claimPrioOut <= '0;
    end else begin
      claimIdOut   <= idNext;
      claimPrioOut <= winPrio;
    end
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_SRC:1]                   pendIn,
  input  logic [NUM_CTX-1:0][NUM_SRC:1]      enIn,
  input  logic [NUM_SRC:1][PRIO_W-1:0]       prioIn,
  input  logic [NUM_CTX-1:0][PRIO_W-1:0]     threshIn,
  output logic [NUM_CTX-1:0][ID_W-1:0]       claimIdOut,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]     claimPrioOut,
  output logic [NUM_CTX-1:0]                 irqOut
);

  ctxStrobe_t [NUM_CTX-1:0]       strobes;
  logic [NUM_CTX-1:0][PRIO_W-1:0] winPrio;

  initial begin
    if (NUM_SRC < 1 || NUM_SRC > SLOT_CNT - 1)
      $error("NUM_SRC out of range");
  end

  irq_arb_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pendIn   (pendIn),
    .enIn     (enIn),
    .prioIn   (prioIn),
    .threshIn (threshIn),
    .winPrio  (winPrio),
    .strobes  (strobes),
    .irqOut   (irqOut)
  );

  irq_arb_dp #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .prioIn       (prioIn),
    .winPrio      (winPrio),
    .claimIdOut   (claimIdOut),
    .claimPrioOut (claimPrioOut)
  );

  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
      // Request only above the threshold seen one edge earlier (R4).
      p_irq_above_thresh_r4: assert property (@(posedge clk) disable iff (!rstN)
        irqOut[c] |-> (claimPrioOut[c] > $past(threshIn[c])));

      // Empty result is fully quiet (R5).
      p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
        (claimIdOut[c] == '0) |-> ((claimPrioOut[c] == '0) && !irqOut[c]));
    end
  endgenerate

  // Steady inputs give steady outputs one registered stage later (R8).
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(pendIn) && $stable(enIn) && $stable(prioIn) &&
     $stable(threshIn))
    |=> ($stable(claimIdOut) && $stable(claimPrioOut) && $stable(irqOut)));

endmodule

// File: tb/irq_prio_arb_bench.sv
module irq_prio_arb_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam int PW   = 3;

  logic                        clk = 1'b0;
  logic                        rstN;
  logic [NSRC:1]               pendIn;
  logic [NCTX-1:0][NSRC:1]     enIn;
  logic [NSRC:1][PW-1:0]       prioIn;
  logic [NCTX-1:0][PW-1:0]     threshIn;
  logic [NCTX-1:0][4:0]        claimIdOut;
  logic [NCTX-1:0][PW-1:0]     claimPrioOut;
  logic [NCTX-1:0]             irqOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arb #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(PW)) u_irq_prio_arb (
    .clk          (clk),
    .rstN         (rstN),
    .pendIn       (pendIn),
    .enIn         (enIn),
    .prioIn       (prioIn),
    .threshIn     (threshIn),
    .claimIdOut   (claimIdOut),
    .claimPrioOut (claimPrioOut),
    .irqOut       (irqOut)
  );

  // Up to three sources get a level, all others are 0. Masks use bit s for
  // source s (bit 0 is dropped when driven).
  typedef struct packed {
    logic [4:0]  srcA; logic [2:0] prA;
    logic [4:0]  srcB; logic [2:0] prB;
    logic [4:0]  srcC; logic [2:0] prC;
    logic [31:0] pend;
    logic [31:0] en0;
    logic [31:0] en1;
    logic [2:0]  th0;  logic [2:0] th1;
    logic [4:0]  id0;  logic [2:0] pr0; logic irq0;
    logic [4:0]  id1;  logic [2:0] pr1; logic irq1;
  } vec_t;

  localparam int VEC_CNT = 5;
  localparam vec_t VECS [VEC_CNT] = '{
    // distinct levels; ctx1 sees only source 5
    '{5'd5, 3'd3, 5'd9, 3'd6, 5'd2, 3'd0, 32'h0000_0224, 32'hFFFF_FFFE, 32'h0000_0020,
      3'd0, 3'd0, 5'd9, 3'd6, 1'b1, 5'd5, 3'd3, 1'b1},
    // tie 4/7 at level 5, threshold equal masks ctx0 but claim id stays
    '{5'd4, 3'd5, 5'd7, 3'd5, 5'd20, 3'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'h0010_0080,
      3'd5, 3'd4, 5'd4, 3'd5, 1'b0, 5'd7, 3'd5, 1'b1},
    // pending sources all at level 0; the level-1 source is not pending
    '{5'd3, 3'd0, 5'd10, 3'd0, 5'd1, 3'd1, 32'h0000_0408, 32'hFFFF_FFFE, 32'hFFFF_FFFE,
      3'd0, 3'd0, 5'd0, 3'd0, 1'b0, 5'd0, 3'd0, 1'b0},
    // top level shared by 1, 30, 31; ctx1 only 31 with threshold 7
    '{5'd31, 3'd7, 5'd1, 3'd7, 5'd30, 3'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'h8000_0000,
      3'd6, 3'd7, 5'd1, 3'd7, 1'b1, 5'd31, 3'd7, 1'b0},
    // enabled but not pending (14) does not take part
    '{5'd12, 3'd1, 5'd13, 3'd2, 5'd14, 3'd3, 32'h0000_3000, 32'h0000_7000, 32'h0000_4000,
      3'd1, 3'd0, 5'd13, 3'd2, 1'b1, 5'd0, 3'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_vec(input vec_t v);
    @(negedge clk);
    prioIn = '0;
    prioIn[v.srcA] = v.prA;
    prioIn[v.srcB] = v.prB;
    prioIn[v.srcC] = v.prC;
    pendIn = v.pend[31:1];
    enIn[0] = v.en0[31:1];
    enIn[1] = v.en1[31:1];
    threshIn[0] = v.th0;
    threshIn[1] = v.th1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    pendIn = '1;
    enIn = '1;
    prioIn = '1;
    threshIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs held at 0 during reset despite live inputs
    check("R8 reset id0", int'(claimIdOut[0]), 0);
    check("R8 reset prio1", int'(claimPrioOut[1]), 0);
    check("R8 reset irq", int'(irqOut), 0);
    rstN = 1'b1;

    // Table walk: R2, R3, R4, R6, R7, R1, R5 per the comments on VECS.
    for (int i = 0; i < VEC_CNT; i++) begin
      apply_vec(VECS[i]);
      @(negedge clk);
      check($sformatf("R2 R3 R7 vec%0d id ctx0", i), int'(claimIdOut[0]), int'(VECS[i].id0));
      check($sformatf("R2 R1 vec%0d prio ctx0", i), int'(claimPrioOut[0]), int'(VECS[i].pr0));
      check($sformatf("R4 R6 vec%0d irq ctx0", i), int'(irqOut[0]), int'(VECS[i].irq0));
      check($sformatf("R7 R5 vec%0d id ctx1", i), int'(claimIdOut[1]), int'(VECS[i].id1));
      check($sformatf("R7 vec%0d prio ctx1", i), int'(claimPrioOut[1]), int'(VECS[i].pr1));
      check($sformatf("R4 vec%0d irq ctx1", i), int'(irqOut[1]), int'(VECS[i].irq1));
    end

    // R8: claim clears pending of 13; old winner visible until the next edge.
    @(negedge clk);
    pendIn[13] = 1'b0;
    #1;
    check("R8 before edge id", int'(claimIdOut[0]), 13);
    @(negedge clk);
    check("R8 next winner id", int'(claimIdOut[0]), 12);
    // R4: level 1 against threshold 1 is masked; R6 id still offered
    check("R4 equal threshold irq", int'(irqOut[0]), 0);
    check("R6 masked winner id", int'(claimIdOut[0]), 12);

    // R4: threshold 0 lets level 1 through
    threshIn[0] = 3'd0;
    @(negedge clk);
    check("R4 zero threshold irq", int'(irqOut[0]), 1);

    // R1: dropping the winner's level to 0 removes it entirely
    prioIn[12] = 3'd0;
    @(negedge clk);
    check("R1 zero level id", int'(claimIdOut[0]), 0);
    check("R5 empty irq", int'(irqOut[0]), 0);

    // R7: disable for ctx0 only; ctx1 picks it up independently
    prioIn[12] = 3'd4;
    enIn[0] = '0;
    enIn[1] = '0;
    enIn[1][12] = 1'b1;
    threshIn[1] = 3'd3;
    @(negedge clk);
    check("R7 disabled ctx0 id", int'(claimIdOut[0]), 0);
    check("R7 enabled ctx1 id", int'(claimIdOut[1]), 12);
    check("R2 ctx1 prio", int'(claimPrioOut[1]), 4);
    check("R4 ctx1 irq", int'(irqOut[1]), 1);

    // R8: reset mid-run clears outputs at the next edge
    rstN = 1'b0;
    @(negedge clk);
    check("R8 reset clears id", int'(claimIdOut[1]), 0);
    check("R8 reset clears irq", int'(irqOut[1]), 0);

    finish_run();
  end

endmodule